// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block produces the signed code that sets a current-output DAC, which pulls a clock oscillator's frequency around its nominal value in a linear triangle pattern. It runs on the reference clock. Its inputs are an enable, a two-bit depth select, a select between a triangle that straddles nominal and one that lies wholly below it, and a select for the long period used when the oscillator multiplies the reference by four. Its outputs are the registered offset code and a one-cycle flag on the first code of every triangle period.

A finite-state machine steps a level count up and back down. A remainder accumulator, similar to a line-drawing error term, spreads exactly twice the selected depth in unit steps over one period of `P` reference cycles. The period may be odd. The triangle therefore closes on itself after exactly `P` cycles, and the offset never moves by more than one code per cycle. Settings are sampled only when a period starts, when the level count is zero.

States: `ST_IDLE` holds the code at zero. `ST_RISE` counts the level up. `ST_FALL` counts it back down. Transitions: IDLE→RISE (start) when enabled with a nonzero depth. RISE→FALL (peak) on the step that brings the level to the selected depth. FALL→RISE (wrap) on the step that returns the level to zero while the block is still enabled with a nonzero depth. FALL→IDLE (stop) on that same step when the block is no longer enabled or the depth is zero. RISE/FALL→IDLE (abort) whenever the enable is low.

Top module: `ssm_profile_gen`

## Requirements
- R1: During and right after reset, `offset_code` is 0 and `period_start` is 0.
- R2: The depth span `D` in code units is 0, FULL_DEPTH/4, FULL_DEPTH/2 and FULL_DEPTH for `depth_sel` = 0, 1, 2 and 3. With the default of 128, full scale stands for a 4% deviation, so the spans are 0%, 1%, 2% and 4% peak to peak.
- R3: With `down_sel`=1 captured, the code is `-level`, which spans from 0 down to `-D`.
- R4: With `down_sel`=0 captured, the code is `D/2 - level`, which spans from `+D/2` to `-D/2`.
- R5: At cycle `k` of a period (k = 0 .. P-1), with `m = floor(2·D·k/P)`, the level is `m` when `m ≤ D` and `2D - m` otherwise. `P` is PERIOD_X1 when `mult4_sel`=0 and PERIOD_X4 when it is 1.
- R6: `period_start` is 1 exactly in the cycle in which cycle 0 of a period is presented, and 0 at all other times.
- R7: If `en` is 0 at a clock edge, or `depth_sel` is 0 when a period would start, the block is idle from the next cycle, with code 0 and the count restarted. An idle block that sees `en`=1 and a nonzero `depth_sel` at an edge presents cycle 0 after that edge.
- R8: Changes to `depth_sel`, `down_sel` or `mult4_sel` in the middle of a period have no effect until the next period starts.
- R9: Within a period, two consecutive codes differ by at most 1.
- R10: A period that ends while `en`=1 and `depth_sel`≠0 is followed at once by cycle 0 of the next period, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Modulation enable |
| depth_sel | input | 2 | Depth select (0 = none, 3 = largest) |
| down_sel | input | 1 | 1 = triangle wholly below nominal, 0 = centred on nominal |
| mult4_sel | input | 1 | 1 = long period PERIOD_X4, 0 = PERIOD_X1 |
| offset_code | output | CODE_W | Signed two's-complement offset code for the DAC |
| period_start | output | 1 | High on the first code of each period |

## Verification
The bench builds the block with PERIOD_X1=300, PERIOD_X4=451 and FULL_DEPTH=128. The short periods allow more than a hundred period boundaries within the run, so settings changes landing in the middle of a period and at its boundary both occur many times. The odd long period exercises the uneven split between the rising and falling halves. Because 2·128 < 300, the largest depth still moves at most one unit per cycle, so the claim of one step per cycle is tested at its limit.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } ssm_state_e;

    // down is the top bit; the checker decodes it there
    typedef struct packed {
        logic       down;
        logic       mult4;
        logic [1:0] depth;
    } ssm_cfg_t;

    function automatic int unsigned depth_span(input logic [1:0] sel, input int unsigned full);
        unique case (sel)
            2'd0:    return 0;
            2'd1:    return full / 4;
            2'd2:    return full / 2;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/ssm_rate_accum.sv
module ssm_rate_accum #(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [ACC_W-1:0] incr,
    input  logic [ACC_W-1:0] modulus,
    output logic             step
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, incr};
        wrapped = sum - {1'b0, modulus};
        step    = run && (sum >= {1'b0, modulus});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= step ? wrapped[ACC_W-1:0] : sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ssm_code_map.sv
module ssm_code_map #(
    parameter int CODE_W = 8,
    parameter int LVL_W  = 8
) (
    input  logic [LVL_W-1:0]         level,
    input  logic [LVL_W-1:0]         span,
    input  logic                     down,
    input  logic                     active,
    output logic signed [CODE_W-1:0] code
);
    localparam int EXT_W = LVL_W + 2;

    logic signed [EXT_W-1:0] lv;
    logic signed [EXT_W-1:0] half;
    logic signed [EXT_W-1:0] raw;

    always_comb begin
        lv   = $signed({2'b00, level});
        half = $signed({2'b00, span}) >>> 1;
        if (!active) begin
            raw = '0;
        end else if (down) begin
            raw = -lv;
        end else begin
            raw = half - lv;
        end
        code = CODE_W'(raw);
    end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen #(
    parameter int CODE_W     = 8,
    parameter int FULL_DEPTH = 128,
    parameter int PERIOD_X1  = 750,
    parameter int PERIOD_X4  = 1125
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [1:0]               depth_sel,
    input  logic                     down_sel,
    input  logic                     mult4_sel,
    output logic signed [CODE_W-1:0] offset_code,
    output logic                     period_start
);
    import ssm_pkg::*;

    localparam int P_MAX = (PERIOD_X4 > PERIOD_X1) ? PERIOD_X4 : PERIOD_X1;
    localparam int ACC_W = $clog2(P_MAX) + 1;
    localparam int LVL_W = $clog2(FULL_DEPTH + 1);

    ssm_state_e state_q, state_d;
    ssm_cfg_t   cfg_q, cfg_d, cfg_in;
    logic [LVL_W-1:0] level_q, level_d;
    logic [LVL_W-1:0] span_q, span_d;
    logic [ACC_W-1:0] incr, modulus;
    logic             step, go, capture, boundary, peak, acc_clear, acc_run;
    logic signed [CODE_W-1:0] code_d;

    always_comb begin
        cfg_in   = '{down: down_sel, mult4: mult4_sel, depth: depth_sel};
        go       = en && (depth_sel != 2'd0);
        span_q   = LVL_W'(depth_span(cfg_q.depth, FULL_DEPTH));
        incr     = ACC_W'(2 * int'(span_q));
        modulus  = ACC_W'(cfg_q.mult4 ? PERIOD_X4 : PERIOD_X1);
        peak     = (state_q == ST_RISE) && step &&
                   (({1'b0, level_q} + 1'b1) == {1'b0, span_q});
        boundary = (state_q == ST_FALL) && step && (level_q == LVL_W'(1));
        capture  = go && ((state_q == ST_IDLE) || boundary);
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = go ? ST_RISE : ST_IDLE;
            ST_RISE: begin
                if (!en)       state_d = ST_IDLE;
                else if (peak) state_d = ST_FALL;
            end
            ST_FALL: begin
                if (!en)           state_d = ST_IDLE;
                else if (boundary) state_d = go ? ST_RISE : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath next values
    always_comb begin
        cfg_d   = capture ? cfg_in : cfg_q;
        span_d  = LVL_W'(depth_span(cfg_d.depth, FULL_DEPTH));
        level_d = level_q;
        if (state_d == ST_IDLE || capture) begin
            level_d = '0;
        end else if (step) begin
            level_d = (state_q == ST_RISE) ? level_q + 1'b1 : level_q - 1'b1;
        end
        acc_clear = (state_q == ST_IDLE) || capture || !en;
        acc_run   = (state_q != ST_IDLE);
    end

    ssm_rate_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .run     (acc_run),
        .incr    (incr),
        .modulus (modulus),
        .step    (step)
    );

    ssm_code_map #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_map (
        .level  (level_d),
        .span   (span_d),
        .down   (cfg_d.down),
        .active (state_d != ST_IDLE),
        .code   (code_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '{down: 1'b1, mult4: 1'b0, depth: 2'd3};
            level_q      <= '0;
            offset_code  <= '0;
            period_start <= 1'b0;
        end else begin
            cfg_q        <= cfg_d;
            level_q      <= level_d;
            offset_code  <= code_d;
            period_start <= capture;
        end
    end
endmodule

// File: rtl/ssm_profile_gen_chk.sv
module ssm_profile_gen_chk #(
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic                     busy,
    input logic [3:0]               cfg_bits,
    input logic signed [CODE_W-1:0] offset_code,
    input logic                     period_start
);
    logic signed [CODE_W-1:0] prev_code;
    logic                     prev_busy;
    logic signed [CODE_W:0]   delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code <= '0;
            prev_busy <= 1'b0;
        end else begin
            prev_code <= offset_code;
            prev_busy <= busy;
        end
    end

    always_comb delta = $signed({offset_code[CODE_W-1], offset_code}) -
                        $signed({prev_code[CODE_W-1], prev_code});

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (offset_code == '0 && !period_start));

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(cfg_bits)) |-> period_start);

    // R3
    down_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_bits[3]) |-> (offset_code <= 0));

    // R9
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prev_busy && !period_start) |-> (delta <= 1 && delta >= -1));
endmodule

bind ssm_profile_gen ssm_profile_gen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .busy         (state_q != ssm_pkg::ST_IDLE),
    .cfg_bits     (cfg_q),
    .offset_code  (offset_code),
    .period_start (period_start)
);

// File: tb/ssm_profile_gen_test.sv
module ssm_profile_gen_test;
    localparam int CODE_W = 8;
    localparam int FULL   = 128;
    localparam int PX1    = 300;
    localparam int PX4    = 451;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic [1:0] depth_sel = 2'd3;
    logic down_sel = 1'b1;
    logic mult4_sel = 1'b0;
    logic signed [CODE_W-1:0] offset_code;
    logic period_start;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_act = 0;
    int m_k = 0, m_D = 0, m_P = PX1;
    bit m_down = 1;
    bit m_cont = 0;
    bit prev_act = 0;
    int prev_code = 0;

    always #2.5 clk = ~clk;

    ssm_profile_gen #(.CODE_W(CODE_W), .FULL_DEPTH(FULL), .PERIOD_X1(PX1), .PERIOD_X4(PX4)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .depth_sel(depth_sel), .down_sel(down_sel),
        .mult4_sel(mult4_sel), .offset_code(offset_code), .period_start(period_start)
    );

    function automatic int span_of(input int sel);
        case (sel)
            0: return 0;
            1: return FULL / 4;
            2: return FULL / 2;
            default: return FULL;
        endcase
    endfunction

    function automatic int level_at(input int k, input int d, input int p);
        int m;
        m = (2 * d * k) / p;
        return (m <= d) ? m : 2 * d - m;
    endfunction

    function automatic int code_exp(input bit act, input int k, input int d, input int p, input bit dn);
        if (!act) return 0;
        return dn ? -level_at(k, d, p) : (d / 2) - level_at(k, d, p);
    endfunction

    task automatic check(input string req, input int act_v, input int exp_v);
        n_checks++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act_v, exp_v, m_k);
        end
    endtask

    task automatic model_edge();
        bit was;
        was = m_act;
        m_cont = 0;
        if (!en) begin
            m_act = 0;
        end else if (!m_act || m_k == m_P - 1) begin
            if (span_of(int'(depth_sel)) == 0) begin
                m_act = 0;
            end else begin
                m_cont = was;
                m_act  = 1;
                m_k    = 0;
                m_D    = span_of(int'(depth_sel));
                m_P    = mult4_sel ? PX4 : PX1;
                m_down = down_sel;
            end
        end else begin
            m_k++;
        end
    endtask

    task automatic compare_outputs();
        int e, a;
        string tag;
        bit differs;
        e = code_exp(m_act, m_k, m_D, m_P, m_down);
        a = int'(offset_code);
        differs = (span_of(int'(depth_sel)) != m_D) || (down_sel != m_down) ||
                  ((mult4_sel ? PX4 : PX1) != m_P);
        if (!m_act)             tag = "R7";
        else if (differs)       tag = "R8";
        else if (m_P == PX4)    tag = "R5";
        else if (m_D != FULL)   tag = "R2";
        else if (m_down)        tag = "R3";
        else                    tag = "R4";
        check(tag, a, e);
        if (m_cont) check("R10", int'(period_start), 1);
        else        check("R6", int'(period_start), int'(m_act && m_k == 0));
        if (m_act && prev_act && !(m_k == 0)) begin
            n_checks++;
            if (a - prev_code > 1 || prev_code - a > 1) begin
                n_fail++;
                $display("FAIL R9: actual step %0d expected at most 1", a - prev_code);
            end
        end
        prev_act  = m_act;
        prev_code = a;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(5.0 * 250000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", int'(offset_code), 0);
        check("R1", int'(period_start), 0);
        rst_n = 1'b1;
        check("R1", int'(offset_code), 0);

        // full-depth down spread, two periods plus margin
        run(2 * PX1 + 5);
        // centred, middle depth; set mid-period so it waits for the boundary
        down_sel = 1'b0; depth_sel = 2'd2;
        run(PX1 + 20);
        // long period, smallest depth
        mult4_sel = 1'b1; depth_sel = 2'd1;
        run(2 * PX4 + 10);
        // depth zero stops at boundary
        depth_sel = 2'd0;
        run(PX4 + 10);
        // restart, then abort mid-period
        depth_sel = 2'd3; down_sel = 1'b0; mult4_sel = 1'b0;
        run(100);
        en = 1'b0;
        run(5);
        en = 1'b1;
        run(PX1 + 3);

        // constrained random
        for (int i = 0; i < 40000; i++) begin
            int r;
            r = int'($urandom % 1000);
            if (r < 2)        en = ~en;
            else if (r < 6)   en = 1'b1;
            else if (r < 12)  depth_sel = 2'($urandom % 4);
            else if (r < 18)  down_sel = ~down_sel;
            else if (r < 22)  mult4_sel = ~mult4_sel;
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule